// File: doc/BRIEF.md
# Clock-Step and Breakpoint Run Controller

This block decides, cycle by cycle, whether a design under observation may advance. It drives a single clock-enable, `run_en`, that the surrounding logic uses to gate the observed design. One controller clock cycle is the base unit of time. The monitored clocks of the observed design are sampled as ordinary data, and their edges are found by comparing successive samples.

A command is issued with a one-cycle `cmd_valid` pulse and is taken only while the controller is halted. There are four run modes. Free run continues until `pause`. Unit step runs for a programmed number of cycles. Edge step runs until a programmed number of edges of the chosen polarity has been seen, on one selected clock or on any of them, and then runs a programmed number of extra settling cycles. Break run continues until a watched value, compared unsigned against a constant, becomes true. A watched value holding unknown bits never counts as true.

Top module: `run_step_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge leaves `halted`=1, `busy`=0 and `run_en`=0 from that edge on, and also ends a run already in progress.
- R2: A `cmd_valid` sampled while halted is accepted, and `run_en` and `busy` are 1 in the next cycle (free and break modes always; step modes when `cmd_count` is non-zero). A `cmd_valid` sampled while busy is ignored, and the current run goes on unchanged.
- R3: In unit-step mode (`cmd_mode`=1), `run_en` is high for exactly `cmd_count` consecutive cycles, and then the block is halted. A count of zero produces no run cycle.
- R4: In edge-step mode (`cmd_mode`=2), a qualifying edge is a change between two successive samples of a `mon_clks` bit: 0 to 1 when `cmd_falling`=0, and 1 to 0 when `cmd_falling`=1. Only samples taken in the main phase of the run count, and the main phase ends on the `cmd_count`-th edge. A count of zero produces no run cycle.
- R5: With `cmd_any_clk`=1, a sample in which one or more `mon_clks` bits show a qualifying edge counts as exactly one edge. With `cmd_any_clk`=0, only bit `cmd_clk_sel` is watched.
- R6: After the sample that holds the final counted edge, `run_en` stays high for exactly `cmd_tail` further cycles. With a tail of zero, it falls in the very next cycle.
- R7: Free-run mode (`cmd_mode`=0) runs until `pause` is sampled high. A `pause` sampled high while running, in any mode, halts the block at that edge.
- R8: In break mode (`cmd_mode`=3), `bp_op` codes 0 to 5 select `watch` == , != , < , <= , > , >= `bp_const`, compared unsigned. The block halts at the edge where the selected condition becomes true.
- R9: `bp_op`=6 breaks when `watch` becomes non-zero, and `bp_op`=7 breaks when it becomes zero.
- R10: A breakpoint fires only on a false-to-true change of its condition. If the condition already holds when the break run starts, the run goes on until the condition has gone false and then true again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one cycle is one base time unit |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, taken only while halted |
| cmd_mode | input | 2 | 0 free run, 1 unit step, 2 edge step, 3 break run |
| cmd_count | input | CNT_W | Cycles (unit step) or edges (edge step) to run |
| cmd_tail | input | CNT_W | Extra settling cycles after the final edge |
| cmd_falling | input | 1 | 0 counts rising edges, 1 counts falling edges |
| cmd_any_clk | input | 1 | 1 counts edges on any monitored clock |
| cmd_clk_sel | input | SEL_W | Monitored clock used when cmd_any_clk is 0 |
| pause | input | 1 | Stops a running command |
| mon_clks | input | NCLK | Sampled clocks of the observed design |
| watch | input | DW | Value watched by the breakpoint |
| bp_const | input | DW | Breakpoint comparison constant |
| bp_op | input | 3 | Breakpoint operator code |
| run_en | output | 1 | Clock-enable for the observed design |
| halted | output | 1 | High while no command is running |
| busy | output | 1 | High while a command runs and new commands are refused |

## Verification
The assertions assume that `mon_clks` holds a defined value during reset. This means the first sample after reset has a real predecessor, and no edge appears out of reset. They also assume that command fields matter only in the cycle in which `cmd_valid` is accepted. The stimulus changes every input half a cycle away from the sampling edge. It keeps `mon_clks` at zero during reset and between commands, so each edge-step run starts from a known level. Watched values and operators are set up at least one cycle before a break run starts.

// File: rtl/run_step_pkg.sv
package run_step_pkg;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_UNITS = 2'd1,
        MODE_EDGES = 2'd2,
        MODE_BREAK = 2'd3
    } run_mode_e;

    typedef enum logic [2:0] {
        OP_EQ   = 3'd0,
        OP_NE   = 3'd1,
        OP_LT   = 3'd2,
        OP_LE   = 3'd3,
        OP_GT   = 3'd4,
        OP_GE   = 3'd5,
        OP_NZ   = 3'd6,
        OP_ZERO = 3'd7
    } cmp_op_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_MAIN = 2'd1,
        ST_TAIL = 2'd2
    } run_state_e;

    // Edge-qualification settings latched with each accepted command
    typedef struct packed {
        run_mode_e mode;
        logic      falling;
        logic      any_clk;
    } step_cfg_t;

    // Operator selection from width-independent comparison flags
    function automatic logic eval_op(cmp_op_e op, logic eq, logic lt, logic nz);
        case (op)
            OP_EQ:   return eq;
            OP_NE:   return !eq;
            OP_LT:   return lt;
            OP_LE:   return lt | eq;
            OP_GT:   return !(lt | eq);
            OP_GE:   return !lt;
            OP_NZ:   return nz;
            default: return !nz;
        endcase
    endfunction

endpackage

// File: rtl/rc_edge_detect.sv
module rc_edge_detect
    import run_step_pkg::*;
#(
    parameter int NCLK  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCLK-1:0]  mon_i,
    input  logic             falling_i,
    input  logic             any_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             edge_o
);

    logic [NCLK-1:0] prev_q;
    logic [NCLK-1:0] lane_hit;

    // Previous sample is loaded in every cycle, reset included, so the first
    // sample after reset always has a defined predecessor.
    always_ff @(posedge clk) begin
        prev_q <= mon_i;
    end

    for (genvar g = 0; g < NCLK; g++) begin : g_lane
        always_comb begin
            if (falling_i) lane_hit[g] = prev_q[g] & ~mon_i[g];
            else           lane_hit[g] = mon_i[g] & ~prev_q[g];
        end
    end

    assign edge_o = any_i ? (|lane_hit) : lane_hit[sel_i];

    AST_EDGE_IS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        edge_o |-> (mon_i != $past(mon_i)));                           // R4

endmodule

// File: rtl/rc_break_cmp.sv
module rc_break_cmp
    import run_step_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] watch_i,
    input  logic [DW-1:0] const_i,
    input  cmp_op_e       op_i,
    output logic          fire_o
);

    logic known;
    logic hit;
    logic hit_q;

    assign known = !$isunknown(watch_i);
    assign hit   = known && eval_op(op_i, watch_i == const_i,
                                    watch_i < const_i, |watch_i);

    // Condition history runs in every cycle, so the fire pulse marks a
    // false-to-true change regardless of when a break run started.
    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= hit;
    end

    assign fire_o = hit & ~hit_q;

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);                                           // R10

endmodule

// File: rtl/rc_sequencer.sv
module rc_sequencer
    import run_step_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid_i,
    input  step_cfg_t        cmd_cfg_i,
    input  logic [SEL_W-1:0] cmd_sel_i,
    input  logic [CNT_W-1:0] cmd_count_i,
    input  logic [CNT_W-1:0] cmd_tail_i,
    input  logic             pause_i,
    input  logic             edge_i,
    input  logic             fire_i,
    output step_cfg_t        cfg_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             running_o
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] NONE = '0;

    run_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] tail_q, tail_d;
    step_cfg_t        cfg_q;
    logic [SEL_W-1:0] sel_q;
    logic             accept;
    logic             open_ended;

    assign accept     = (st_q == ST_HALT) && cmd_valid_i;
    assign open_ended = (cmd_cfg_i.mode == MODE_FREE) || (cmd_cfg_i.mode == MODE_BREAK);

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        tail_d = tail_q;
        case (st_q)
            ST_HALT: begin
                if (cmd_valid_i) begin
                    cnt_d  = cmd_count_i;
                    tail_d = cmd_tail_i;
                    if (open_ended || (cmd_count_i != NONE)) st_d = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (pause_i) begin
                    st_d = ST_HALT;
                end else begin
                    case (cfg_q.mode)
                        MODE_UNITS: begin
                            cnt_d = cnt_q - ONE;
                            if (cnt_q == ONE) st_d = ST_HALT;
                        end
                        MODE_EDGES: begin
                            if (edge_i) begin
                                cnt_d = cnt_q - ONE;
                                if (cnt_q == ONE)
                                    st_d = (tail_q == NONE) ? ST_HALT : ST_TAIL;
                            end
                        end
                        MODE_BREAK: begin
                            if (fire_i) st_d = ST_HALT;
                        end
                        default: ;
                    endcase
                end
            end
            ST_TAIL: begin
                if (pause_i || (tail_q == ONE)) st_d = ST_HALT;
                else                            tail_d = tail_q - ONE;
            end
            default: st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HALT;
            cnt_q  <= '0;
            tail_q <= '0;
            cfg_q  <= '{mode: MODE_FREE, falling: 1'b0, any_clk: 1'b0};
            sel_q  <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            tail_q <= tail_d;
            if (accept) begin
                cfg_q <= cmd_cfg_i;
                sel_q <= cmd_sel_i;
            end
        end
    end

    assign cfg_o     = cfg_q;
    assign sel_o     = sel_q;
    assign running_o = (st_q != ST_HALT);

    AST_START_FREE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT && cmd_valid_i && cmd_cfg_i.mode == MODE_FREE)
        |=> (st_q == ST_MAIN));                                        // R2
    AST_BUSY_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_HALT && cmd_valid_i) |=> ($stable(cfg_q) && $stable(sel_q))); // R2
    AST_UNIT_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MAIN && cfg_q.mode == MODE_UNITS && !pause_i && cnt_q > ONE)
        |=> (st_q == ST_MAIN && cnt_q == $past(cnt_q) - ONE));         // R3
    AST_TAIL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TAIL) |-> (tail_q != NONE));                       // R6
    AST_PAUSE_HALTS: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_HALT && pause_i) |=> (st_q == ST_HALT));           // R7
    AST_FIRE_HALTS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MAIN && cfg_q.mode == MODE_BREAK && fire_i)
        |=> (st_q == ST_HALT));                                        // R8

endmodule

// File: rtl/run_step_ctrl.sv
module run_step_ctrl
    import run_step_pkg::*;
#(
    parameter int NCLK  = 4,
    parameter int DW    = 16,
    parameter int CNT_W = 16,
    parameter int SEL_W = (NCLK > 1) ? $clog2(NCLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_mode,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [CNT_W-1:0] cmd_tail,
    input  logic             cmd_falling,
    input  logic             cmd_any_clk,
    input  logic [SEL_W-1:0] cmd_clk_sel,
    input  logic             pause,
    input  logic [NCLK-1:0]  mon_clks,
    input  logic [DW-1:0]    watch,
    input  logic [DW-1:0]    bp_const,
    input  logic [2:0]       bp_op,
    output logic             run_en,
    output logic             halted,
    output logic             busy
);

    step_cfg_t        cmd_cfg;
    step_cfg_t        cfg_q;
    logic [SEL_W-1:0] sel_q;
    logic             edge_seen;
    logic             bp_fire;
    logic             running;

    assign cmd_cfg = '{mode: run_mode_e'(cmd_mode), falling: cmd_falling,
                       any_clk: cmd_any_clk};

    rc_edge_detect #(.NCLK(NCLK), .SEL_W(SEL_W)) edge_i (
        .clk       (clk),
        .rst       (rst),
        .mon_i     (mon_clks),
        .falling_i (cfg_q.falling),
        .any_i     (cfg_q.any_clk),
        .sel_i     (sel_q),
        .edge_o    (edge_seen)
    );

    rc_break_cmp #(.DW(DW)) cmp_i (
        .clk     (clk),
        .rst     (rst),
        .watch_i (watch),
        .const_i (bp_const),
        .op_i    (cmp_op_e'(bp_op)),
        .fire_o  (bp_fire)
    );

    rc_sequencer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid),
        .cmd_cfg_i   (cmd_cfg),
        .cmd_sel_i   (cmd_clk_sel),
        .cmd_count_i (cmd_count),
        .cmd_tail_i  (cmd_tail),
        .pause_i     (pause),
        .edge_i      (edge_seen),
        .fire_i      (bp_fire),
        .cfg_o       (cfg_q),
        .sel_o       (sel_q),
        .running_o   (running)
    );

    assign run_en = running;
    assign busy   = running;
    assign halted = !running;

endmodule

// File: tb/run_step_ctrl_tb.sv
module run_step_ctrl_tb_top;

    localparam int NCLK  = 4;
    localparam int DW    = 16;
    localparam int CNT_W = 16;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_mode = '0;
    logic [CNT_W-1:0] cmd_count = '0;
    logic [CNT_W-1:0] cmd_tail = '0;
    logic             cmd_falling = 1'b0;
    logic             cmd_any_clk = 1'b0;
    logic [SEL_W-1:0] cmd_clk_sel = '0;
    logic             pause = 1'b0;
    logic [NCLK-1:0]  mon_clks = '0;
    logic [DW-1:0]    watch = '0;
    logic [DW-1:0]    bp_const = '0;
    logic [2:0]       bp_op = '0;
    logic             run_en, halted, busy;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    run_step_ctrl #(.NCLK(NCLK), .DW(DW), .CNT_W(CNT_W), .SEL_W(SEL_W)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_count(cmd_count), .cmd_tail(cmd_tail), .cmd_falling(cmd_falling),
        .cmd_any_clk(cmd_any_clk), .cmd_clk_sel(cmd_clk_sel), .pause(pause),
        .mon_clks(mon_clks), .watch(watch), .bp_const(bp_const), .bp_op(bp_op),
        .run_en(run_en), .halted(halted), .busy(busy)
    );

    // Step vectors: clock lane k toggles every hK cycles (0 = held low)
    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] cnt;
        logic [7:0] tail;
        logic       fall;
        logic       any;
        logic [1:0] sel;
        logic [3:0] h0;
        logic [3:0] h1;
        logic [7:0] exp_len;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 8'd5, 8'd0, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0, 8'd5},
        '{2'd1, 8'd1, 8'd0, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0, 8'd1},
        '{2'd1, 8'd0, 8'd0, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0, 8'd0},
        '{2'd2, 8'd2, 8'd0, 1'b0, 1'b0, 2'd0, 4'd2, 4'd0, 8'd7},
        '{2'd2, 8'd2, 8'd3, 1'b0, 1'b0, 2'd0, 4'd2, 4'd0, 8'd10},
        '{2'd2, 8'd1, 8'd0, 1'b1, 1'b0, 2'd0, 4'd3, 4'd0, 8'd7},
        '{2'd2, 8'd2, 8'd0, 1'b0, 1'b0, 2'd1, 4'd2, 4'd3, 8'd10},
        '{2'd2, 8'd3, 8'd2, 1'b0, 1'b1, 2'd0, 4'd2, 4'd3, 8'd9},
        '{2'd2, 8'd4, 8'd1, 1'b1, 1'b1, 2'd0, 4'd2, 4'd3, 8'd14},
        '{2'd2, 8'd0, 8'd0, 1'b0, 1'b1, 2'd0, 4'd2, 4'd3, 8'd0}
    };

    localparam logic [DW-1:0] FALSE_V [8] = '{16'h0010, 16'h0040, 16'h0040, 16'h0041,
                                              16'h0040, 16'h003F, 16'h0000, 16'h0007};
    localparam logic [DW-1:0] TRUE_V  [8] = '{16'h0040, 16'h0041, 16'h003F, 16'h0040,
                                              16'h0041, 16'h0040, 16'h0005, 16'h0000};

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic issue(input logic [1:0] mode, input int cnt, input int tail);
        @(negedge clk);
        cmd_mode  = mode;
        cmd_count = CNT_W'(cnt);
        cmd_tail  = CNT_W'(tail);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int len = 0;
        @(negedge clk);
        mon_clks    = '0;
        cmd_mode    = v.mode;
        cmd_count   = CNT_W'(v.cnt);
        cmd_tail    = CNT_W'(v.tail);
        cmd_falling = v.fall;
        cmd_any_clk = v.any;
        cmd_clk_sel = v.sel;
        cmd_valid   = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int j = 0; j < 200; j++) begin
            if (!run_en) break;
            len++;
            mon_clks[0] = (v.h0 != 0) && (((j / int'(v.h0)) % 2) == 1);
            mon_clks[1] = (v.h1 != 0) && (((j / int'(v.h1)) % 2) == 1);
            @(negedge clk);
        end
        mon_clks = '0;
        if (v.mode == 2'd1)
            chk($sformatf("R3 unit step vector %0d run length", idx), len, int'(v.exp_len));
        else
            chk($sformatf("R4 R5 R6 edge step vector %0d run length", idx), len, int'(v.exp_len));
        chk($sformatf("R3 R4 halted after vector %0d", idx), int'(halted), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 run_en in reset", int'(run_en), 0);
        chk("R1 halted in reset", int'(halted), 1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);

        // R3 R4 R5 R6: table of step commands
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R2 R7: free run, command refused while busy, then pause
        issue(2'd0, 0, 0);
        chk("R2 run_en after accept", int'(run_en), 1);
        chk("R2 busy after accept", int'(busy), 1);
        repeat (5) @(negedge clk);
        chk("R7 free run continues", int'(run_en), 1);
        issue(2'd1, 2, 0);
        repeat (4) @(negedge clk);
        chk("R2 command while busy ignored", int'(run_en), 1);
        pause = 1'b1;
        @(negedge clk);
        pause = 1'b0;
        chk("R7 pause halts free run", int'(halted), 1);

        // R7: pause during an edge step that sees no edges
        cmd_falling = 1'b0; cmd_any_clk = 1'b1;
        issue(2'd2, 5, 0);
        repeat (3) @(negedge clk);
        chk("R7 edge step waiting", int'(run_en), 1);
        pause = 1'b1;
        @(negedge clk);
        pause = 1'b0;
        chk("R7 pause halts edge step", int'(run_en), 0);

        // R8 R9: each operator, false value first then true value
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            bp_op    = 3'(k);
            bp_const = 16'h0040;
            watch    = FALSE_V[k];
            issue(2'd3, 0, 0);
            repeat (3) @(negedge clk);
            chk($sformatf("%s op %0d no early break", (k >= 6) ? "R9" : "R8", k), int'(run_en), 1);
            watch = TRUE_V[k];
            @(negedge clk);
            chk($sformatf("%s op %0d break halts", (k >= 6) ? "R9" : "R8", k), int'(halted), 1);
        end

        // R10: condition already true at start only fires after a fresh rise
        @(negedge clk);
        bp_op = 3'd5; bp_const = 16'h0040; watch = 16'h0050;
        repeat (2) @(negedge clk);
        issue(2'd3, 0, 0);
        repeat (4) @(negedge clk);
        chk("R10 held condition does not break", int'(run_en), 1);
        watch = 16'h0010;
        @(negedge clk);
        chk("R10 false condition keeps running", int'(run_en), 1);
        watch = 16'h0050;
        @(negedge clk);
        chk("R10 fresh rise breaks", int'(halted), 1);

        // R1: reset ends a run in progress
        issue(2'd0, 0, 0);
        chk("R1 running before reset", int'(run_en), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset aborts run", int'(halted), 1);
        chk("R1 busy cleared by reset", int'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule